// File: doc/BRIEF.md
# Split Dual 8-Bit Reload Timer

The block holds two independent 8-bit up-counters, a low half and a high half. When a half passes 0xFF it does not wrap to 0x00. It loads the value in its own reload register, raises a sticky overflow flag, and drives a one-cycle overflow pulse that other logic can use as a trigger. The low half counts whenever its tick is enabled. The high half counts only while the run bit is set.

Each half chooses its count tick with its own fast-select bit. A set bit counts on every system clock. A clear bit hands the choice to a shared source-select bit: 0 selects the system clock divided by 12, and 1 selects an external clock divided by 8. The external clock passes through a synchroniser and a rising-edge detector, so all counting runs on system-clock enables. Software writes the configuration, the reload values, the counter values and the flags through plain write strobes. A single interrupt request combines the two flags. By default it follows the high flag only. An enable bit adds the low flag.

Top module: `split_reload_timer`

## Requirements
- R1: Reset clears both counters, both reload registers, both flags, every configuration bit and the interrupt request.
- R2: The low half advances by one on every enabled tick whatever the run bit holds.
- R3: The high half holds its value while the run bit is 0 and advances on each enabled tick while the run bit is 1.
- R4: On an enabled tick at 0xFF a half loads its reload value instead of 0x00 and sets its own overflow flag.
- R5: With the half's fast bit at 1 the half ticks on every system clock. With the fast bit at 0 and the source bit at 0 it ticks exactly once in every 12 system clocks.
- R6: With the fast bit at 0 and the source bit at 1, a half ticks once for every 8 rising edges of the external clock, provided each high and each low phase lasts at least two system clocks.
- R7: A flag stays set until software writes 0 to it through the flag write strobe.
- R8: irq is 0 while the interrupt enable bit is 0. When that bit is 1, irq follows the high flag alone if the low-interrupt bit is 0, and follows the OR of both flags if the low-interrupt bit is 1.
- R9: If software writes 0 to a flag in the same cycle that the hardware sets it, the flag ends up set.
- R10: A half's overflow pulse is 1 in exactly those cycles in which the half sits at 0xFF with its tick enabled and no counter write pending, and it is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk | input | 1 | Asynchronous external count clock |
| cfg_we | input | 1 | Write strobe for the configuration bits |
| cfg_run | input | 1 | Run bit for the high half |
| cfg_lo_fast | input | 1 | Low half counts on every system clock |
| cfg_hi_fast | input | 1 | High half counts on every system clock |
| cfg_ext_sel | input | 1 | Shared slow source: 0 = clock/12, 1 = external/8 |
| cfg_lo_irq_en | input | 1 | Adds the low flag to the interrupt |
| cfg_irq_en | input | 1 | Interrupt enable |
| rld_we | input | 1 | Write strobe for both reload registers |
| rld_lo_wdata | input | 8 | Low reload value |
| rld_hi_wdata | input | 8 | High reload value |
| cnt_we | input | 1 | Write strobe for both counters (takes priority over counting) |
| cnt_lo_wdata | input | 8 | Low counter value |
| cnt_hi_wdata | input | 8 | High counter value |
| flag_we | input | 1 | Write strobe for both flags |
| flag_lo_wdata | input | 1 | Low flag value |
| flag_hi_wdata | input | 1 | High flag value |
| cnt_lo | output | 8 | Low counter |
| cnt_hi | output | 8 | High counter |
| flag_lo | output | 1 | Low overflow flag |
| flag_hi | output | 1 | High overflow flag |
| ovf_lo | output | 1 | Low overflow pulse |
| ovf_hi | output | 1 | High overflow pulse |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a software clear that lands in the same cycle as a hardware overflow. The stimulus gets there by loading the low counter with 0xFE in fast mode, so the overflow cycle is known exactly, and then driving a flag write of 0 for that one cycle. The external divider runs at a phase that depends on earlier traffic. The stimulus therefore sends a whole multiple of 8 edges and lets the pipeline drain, so the expected tick count does not depend on that phase.

// File: rtl/srt_pkg.sv
package srt_pkg;

    localparam int NUM_HALF = 2;
    localparam int LO = 0;
    localparam int HI = 1;

    typedef struct packed {
        logic run;
        logic lo_fast;
        logic hi_fast;
        logic ext_sel;
        logic lo_irq_en;
        logic irq_en;
    } srt_cfg_t;

    typedef struct packed {
        logic sys_div;
        logic ext_div;
    } srt_ticks_t;

    function automatic logic pick_tick(input logic fast, input logic ext_sel,
                                       input srt_ticks_t t);
        if (fast)
            return 1'b1;
        return ext_sel ? t.ext_div : t.sys_div;
    endfunction

endpackage

// File: rtl/srt_prescale.sv
module srt_prescale
    import srt_pkg::*;
#(
    parameter int DIV_SYS = 12,
    parameter int DIV_EXT = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ext_clk,
    output srt_ticks_t ticks
);
    localparam int SW = $clog2(DIV_SYS);
    localparam int EW = $clog2(DIV_EXT);
    localparam logic [SW-1:0] SYS_LAST = SW'(DIV_SYS - 1);
    localparam logic [EW-1:0] EXT_LAST = EW'(DIV_EXT - 1);

    logic [SW-1:0] sys_cnt;
    logic [EW-1:0] ext_cnt;
    logic [SYNC_STAGES-1:0] sync_q;
    logic prev_q;
    logic ext_rise;

    always_ff @(posedge clk) begin
        if (rst)
            sys_cnt <= '0;
        else if (sys_cnt == SYS_LAST)
            sys_cnt <= '0;
        else
            sys_cnt <= sys_cnt + 1'b1;
    end

    genvar s;
    generate
        for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst)
                    sync_q[s] <= 1'b0;
                else if (s == 0)
                    sync_q[s] <= ext_clk;
                else
                    sync_q[s] <= sync_q[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= 1'b0;
        else
            prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign ext_rise = sync_q[SYNC_STAGES-1] & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst)
            ext_cnt <= '0;
        else if (ext_rise)
            ext_cnt <= (ext_cnt == EXT_LAST) ? '0 : ext_cnt + 1'b1;
    end

    assign ticks.sys_div = (sys_cnt == SYS_LAST);
    assign ticks.ext_div = ext_rise && (ext_cnt == EXT_LAST);

endmodule

// File: rtl/srt_half.sv
module srt_half #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] rld,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    assign ovf = en && !load && (cnt == TOP);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (en)
            cnt <= (cnt == TOP) ? rld : cnt + 1'b1;
    end

endmodule

// File: rtl/split_reload_timer.sv
module split_reload_timer
    import srt_pkg::*;
#(
    parameter int W = 8,
    parameter int DIV_SYS = 12,
    parameter int DIV_EXT = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ext_clk,
    input  logic         cfg_we,
    input  logic         cfg_run,
    input  logic         cfg_lo_fast,
    input  logic         cfg_hi_fast,
    input  logic         cfg_ext_sel,
    input  logic         cfg_lo_irq_en,
    input  logic         cfg_irq_en,
    input  logic         rld_we,
    input  logic [W-1:0] rld_lo_wdata,
    input  logic [W-1:0] rld_hi_wdata,
    input  logic         cnt_we,
    input  logic [W-1:0] cnt_lo_wdata,
    input  logic [W-1:0] cnt_hi_wdata,
    input  logic         flag_we,
    input  logic         flag_lo_wdata,
    input  logic         flag_hi_wdata,
    output logic [W-1:0] cnt_lo,
    output logic [W-1:0] cnt_hi,
    output logic         flag_lo,
    output logic         flag_hi,
    output logic         ovf_lo,
    output logic         ovf_hi,
    output logic         irq
);
    srt_cfg_t   cfg_q;
    srt_ticks_t ticks;

    logic [W-1:0] rld_q   [NUM_HALF];
    logic [W-1:0] wr_val  [NUM_HALF];
    logic [W-1:0] cnt_v   [NUM_HALF];
    logic [NUM_HALF-1:0] en;
    logic [NUM_HALF-1:0] ovf;
    logic [NUM_HALF-1:0] flag_q;
    logic [NUM_HALF-1:0] flag_wd;
    logic [NUM_HALF-1:0] fast;
    logic [NUM_HALF-1:0] gate;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (cfg_we)
            cfg_q <= '{run: cfg_run, lo_fast: cfg_lo_fast, hi_fast: cfg_hi_fast,
                       ext_sel: cfg_ext_sel, lo_irq_en: cfg_lo_irq_en,
                       irq_en: cfg_irq_en};
    end

    srt_prescale #(
        .DIV_SYS(DIV_SYS),
        .DIV_EXT(DIV_EXT),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_pre (
        .clk(clk),
        .rst(rst),
        .ext_clk(ext_clk),
        .ticks(ticks)
    );

    assign wr_val[LO]  = cnt_lo_wdata;
    assign wr_val[HI]  = cnt_hi_wdata;
    assign flag_wd[LO] = flag_lo_wdata;
    assign flag_wd[HI] = flag_hi_wdata;
    assign fast[LO]    = cfg_q.lo_fast;
    assign fast[HI]    = cfg_q.hi_fast;
    assign gate[LO]    = 1'b1;
    assign gate[HI]    = cfg_q.run;

    genvar h;
    generate
        for (h = 0; h < NUM_HALF; h++) begin : g_half
            always_ff @(posedge clk) begin
                if (rst)
                    rld_q[h] <= '0;
                else if (rld_we)
                    rld_q[h] <= (h == LO) ? rld_lo_wdata : rld_hi_wdata;
            end

            assign en[h] = gate[h] && pick_tick(fast[h], cfg_q.ext_sel, ticks);

            srt_half #(.W(W)) u_half (
                .clk(clk),
                .rst(rst),
                .en(en[h]),
                .load(cnt_we),
                .load_val(wr_val[h]),
                .rld(rld_q[h]),
                .cnt(cnt_v[h]),
                .ovf(ovf[h])
            );

            always_ff @(posedge clk) begin
                if (rst)
                    flag_q[h] <= 1'b0;
                else if (ovf[h])
                    flag_q[h] <= 1'b1;
                else if (flag_we)
                    flag_q[h] <= flag_wd[h];
            end
        end
    endgenerate

    assign cnt_lo  = cnt_v[LO];
    assign cnt_hi  = cnt_v[HI];
    assign flag_lo = flag_q[LO];
    assign flag_hi = flag_q[HI];
    assign ovf_lo  = ovf[LO];
    assign ovf_hi  = ovf[HI];
    assign irq     = cfg_q.irq_en && (flag_q[HI] || (cfg_q.lo_irq_en && flag_q[LO]));

endmodule

// File: rtl/srt_checker.sv
module srt_checker
    import srt_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         cnt_we,
    input logic         flag_we,
    input srt_cfg_t     cfg_q,
    input logic [W-1:0] rld_lo_q,
    input logic [W-1:0] cnt_lo,
    input logic [W-1:0] cnt_hi,
    input logic         flag_lo,
    input logic         flag_hi,
    input logic         ovf_lo,
    input logic         ovf_hi,
    input logic         irq
);
    // R4: after a low overflow the counter holds the reload value
    a_r4_reload_lo: assert property (@(posedge clk) disable iff (rst)
        ovf_lo |=> (cnt_lo == $past(rld_lo_q)));

    // R9: an overflow always leaves its flag set, even with a clear pending
    a_r9_set_wins_lo: assert property (@(posedge clk) disable iff (rst)
        ovf_lo |=> flag_lo);
    a_r9_set_wins_hi: assert property (@(posedge clk) disable iff (rst)
        ovf_hi |=> flag_hi);

    // R7: without a software write a set flag stays set
    a_r7_flag_hold_lo: assert property (@(posedge clk) disable iff (rst)
        (flag_lo && !flag_we) |=> flag_lo);

    // R3: the high half is frozen while the run bit is clear
    a_r3_hi_hold: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.run && !cnt_we) |=> $stable(cnt_hi));

    // R8: interrupt gating
    a_r8_irq_off: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.irq_en |-> !irq);
    a_r8_irq_source: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flag_hi || flag_lo));

    // R10: a pulse only happens at the top count
    a_r10_pulse_at_top: assert property (@(posedge clk) disable iff (rst)
        ovf_lo |-> (cnt_lo == {W{1'b1}}));

endmodule

bind split_reload_timer srt_checker #(.W(W)) u_chk (
    .clk(clk),
    .rst(rst),
    .cnt_we(cnt_we),
    .flag_we(flag_we),
    .cfg_q(cfg_q),
    .rld_lo_q(rld_q[srt_pkg::LO]),
    .cnt_lo(cnt_lo),
    .cnt_hi(cnt_hi),
    .flag_lo(flag_lo),
    .flag_hi(flag_hi),
    .ovf_lo(ovf_lo),
    .ovf_hi(ovf_hi),
    .irq(irq)
);

// File: tb/split_reload_timer_test.sv
module split_reload_timer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_clk = 1'b0;
    logic       cfg_we = 1'b0, cfg_run = 1'b0, cfg_lo_fast = 1'b0, cfg_hi_fast = 1'b0;
    logic       cfg_ext_sel = 1'b0, cfg_lo_irq_en = 1'b0, cfg_irq_en = 1'b0;
    logic       rld_we = 1'b0;
    logic [7:0] rld_lo_wdata = '0, rld_hi_wdata = '0;
    logic       cnt_we = 1'b0;
    logic [7:0] cnt_lo_wdata = '0, cnt_hi_wdata = '0;
    logic       flag_we = 1'b0, flag_lo_wdata = 1'b0, flag_hi_wdata = 1'b0;
    logic [7:0] cnt_lo, cnt_hi;
    logic       flag_lo, flag_hi, ovf_lo, ovf_hi, irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    split_reload_timer uut (
        .clk(clk), .rst(rst), .ext_clk(ext_clk),
        .cfg_we(cfg_we), .cfg_run(cfg_run), .cfg_lo_fast(cfg_lo_fast),
        .cfg_hi_fast(cfg_hi_fast), .cfg_ext_sel(cfg_ext_sel),
        .cfg_lo_irq_en(cfg_lo_irq_en), .cfg_irq_en(cfg_irq_en),
        .rld_we(rld_we), .rld_lo_wdata(rld_lo_wdata), .rld_hi_wdata(rld_hi_wdata),
        .cnt_we(cnt_we), .cnt_lo_wdata(cnt_lo_wdata), .cnt_hi_wdata(cnt_hi_wdata),
        .flag_we(flag_we), .flag_lo_wdata(flag_lo_wdata), .flag_hi_wdata(flag_hi_wdata),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .flag_lo(flag_lo), .flag_hi(flag_hi),
        .ovf_lo(ovf_lo), .ovf_hi(ovf_hi), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input logic run, input logic lof, input logic hif,
                           input logic ext, input logic loie, input logic ie);
        cfg_run = run; cfg_lo_fast = lof; cfg_hi_fast = hif;
        cfg_ext_sel = ext; cfg_lo_irq_en = loie; cfg_irq_en = ie;
        cfg_we = 1'b1;
    endtask

    // One write cycle: configuration, reload, counters and a flag clear together
    task automatic setup(input logic run, input logic lof, input logic hif,
                         input logic ext, input logic loie, input logic ie,
                         input logic [7:0] rl, input logic [7:0] rh,
                         input logic [7:0] cl, input logic [7:0] ch);
        set_cfg(run, lof, hif, ext, loie, ie);
        rld_lo_wdata = rl; rld_hi_wdata = rh; rld_we = 1'b1;
        cnt_lo_wdata = cl; cnt_hi_wdata = ch; cnt_we = 1'b1;
        flag_lo_wdata = 1'b0; flag_hi_wdata = 1'b0; flag_we = 1'b1;
        step(1);
        cfg_we = 1'b0; rld_we = 1'b0; cnt_we = 1'b0; flag_we = 1'b0;
    endtask

    task automatic cfg_only(input logic run, input logic lof, input logic hif,
                            input logic ext, input logic loie, input logic ie);
        set_cfg(run, lof, hif, ext, loie, ie);
        step(1);
        cfg_we = 1'b0;
    endtask

    function automatic int model(input int rl, input int start, input int k);
        int v = start;
        for (int i = 0; i < k; i++)
            v = (v == 255) ? rl : v + 1;
        return v;
    endfunction

    initial begin
        #1500000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R1: reset state
        check("R1 cnt_lo", cnt_lo, 0);
        check("R1 cnt_hi", cnt_hi, 0);
        check("R1 flags", {flag_hi, flag_lo}, 0);
        check("R1 irq", irq, 0);

        // R2 / R3: low half ignores run bit, high half waits for it
        setup(0, 1, 1, 0, 0, 0, 8'd0, 8'd0, 8'd10, 8'd20);
        step(5);
        check("R2 low counts with run=0", cnt_lo, 15);
        check("R3 high holds with run=0", cnt_hi, 20);
        cfg_only(1, 1, 1, 0, 0, 0);
        step(5);
        check("R2 low keeps counting", cnt_lo, 21);
        check("R3 high counts with run=1", cnt_hi, 25);

        // R4 / R5 fast mode: sweep of reload values
        for (int r = 0; r < 256; r += 15) begin
            setup(1, 1, 1, 0, 0, 1, 8'(r), 8'(255 - r), 8'(r), 8'(255 - r));
            step(300);
            check("R4 R5 low after reload sweep", cnt_lo, model(r, r, 300));
            check("R4 R5 high after reload sweep", cnt_hi, model(255 - r, 255 - r, 300));
            check("R4 flags set", {flag_hi, flag_lo}, 3);
            check("R8 irq from high flag", irq, 1);
        end

        // R5: divide by 12
        setup(1, 0, 0, 0, 0, 0, 8'd0, 8'd0, 8'd0, 8'd0);
        step(120);
        check("R5 low div12", cnt_lo, 10);
        check("R5 high div12", cnt_hi, 10);

        // R6: external clock divided by 8
        setup(1, 0, 0, 1, 0, 0, 8'd0, 8'd0, 8'd0, 8'd0);
        for (int e = 0; e < 32; e++) begin
            ext_clk = 1'b1; step(2);
            ext_clk = 1'b0; step(2);
        end
        step(8);
        check("R6 low ext div8", cnt_lo, 4);
        check("R6 high ext div8", cnt_hi, 4);

        // R7 / R8: low overflow only, then interrupt gating
        setup(0, 1, 0, 0, 0, 1, 8'd0, 8'd0, 8'hFE, 8'd0);
        step(2);
        check("R4 low flag set", flag_lo, 1);
        check("R4 high flag clear", flag_hi, 0);
        check("R8 low flag ignored without low enable", irq, 0);
        cfg_only(0, 1, 0, 0, 1, 1);
        check("R8 low flag raises irq with low enable", irq, 1);
        cfg_only(0, 1, 0, 0, 1, 0);
        check("R8 irq off when disabled", irq, 0);
        step(50);
        check("R7 flag sticky", flag_lo, 1);
        flag_lo_wdata = 1'b0; flag_hi_wdata = 1'b0; flag_we = 1'b1;
        step(1);
        flag_we = 1'b0;
        check("R7 flag cleared by write", flag_lo, 0);

        // R9 / R10: clear collides with overflow
        setup(0, 1, 0, 0, 0, 0, 8'h40, 8'd0, 8'hFE, 8'd0);
        check("R10 no pulse below top", ovf_lo, 0);
        step(1);
        check("R10 pulse at top", ovf_lo, 1);
        check("R10 no high pulse", ovf_hi, 0);
        flag_lo_wdata = 1'b0; flag_we = 1'b1;
        step(1);
        flag_we = 1'b0;
        check("R9 set wins over clear", flag_lo, 1);
        check("R10 pulse ends", ovf_lo, 0);
        check("R4 reload value", cnt_lo, 8'h40);

        // R1: reset during operation
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        check("R1 mid-run reset counters", {cnt_hi, cnt_lo}, 0);
        check("R1 mid-run reset flags", {flag_hi, flag_lo}, 0);
        step(3);
        check("R1 config cleared, high held", cnt_hi, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule